// File: doc/BRIEF.md
# Host Data Blit Unpacker

This block sits behind the data port of a 2D drawing engine during a host-to-screen copy. Software programs a destination corner, a width and height (each written as size minus one) and a pixel depth code, then streams the picture as 32-bit words. The block splits each word into pixels of 1, 2 or 4 bytes and issues one framebuffer write per pixel, with a byte address and zero-extended pixel data. Rows are written top to bottom and, within a row, left to right.

Every scanline in the host stream is padded up to a whole number of 32-bit words. The block uses the real pixels of the final word of a row, throws away that word's pad bytes, and starts the next row at the lowest byte of a fresh word. It holds one word at a time and lowers its ready output until every pixel of that word has been written. When the last pixel of the last row goes out, it pulses done and returns to idle. It takes no further words until the next start.

The framebuffer byte address of a pixel is (dst_y + row) × PITCH_BYTES + (dst_x + col) × bytes-per-pixel. The framebuffer side has no backpressure and takes one write per cycle.

Top module: `hblit_unpack`

## Requirements
- R1: While reset is high, and in the first cycle after it, in_ready_o, pix_valid_o, done_o and busy_o are all 0.
- R2: A start_i pulse taken while idle latches dst_x_i, dst_y_i, w_m1_i, h_m1_i and depth_i. In the cycle after that edge, busy_o and in_ready_o are 1.
- R3: Depth code 3'b000 gives 1 byte per pixel, 3'b001 gives 2 and 3'b010 gives 4. Any other code acts as 1 byte per pixel. Bits 7:0 of a word hold the earliest byte of the stream, and each later byte sits 8 bits higher. A pixel's first byte lands in pix_data_o[7:0], and the bits above the pixel size are 0.
- R4: Each row takes ceil((w_m1+1) × bpp / 4) words. The pad bytes in a row's final word are never written out, and the next row's first pixel comes from bits 7:0 of the next word.
- R5: The pixel write for row r, column c has pix_addr_o = (dst_y + r) × PITCH_BYTES + (dst_x + c) × bpp. Writes come out row by row from r = 0 and, within a row, from c = 0 upward.
- R6: One blit issues exactly (w_m1+1) × (h_m1+1) pixel writes, and pix_valid_o is high only while the block is busy or during the done cycle.
- R7: While a word is held, in_ready_o is 0. It is 0 in the cycle after any accepted word.
- R8: Pixels of a held word come out one per cycle. The first pixel of a word is visible after the second rising edge, counting the edge that accepted the word as the first.
- R9: done_o is a one-cycle pulse that coincides with the final pixel write. busy_o and in_ready_o are 0 in that same cycle.
- R10: After done_o, words offered on in_valid_i are not accepted (in_ready_o stays 0) and no pixel writes occur until the next start.
- R11: A start_i pulse while busy is ignored. The running blit's geometry, depth and pixel sequence are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a blit (taken only when idle) |
| dst_x_i | input | XW | Destination left column |
| dst_y_i | input | YW | Destination top row |
| w_m1_i | input | XW | Width minus one, in pixels |
| h_m1_i | input | YW | Height minus one, in rows |
| depth_i | input | 3 | Pixel depth code |
| in_valid_i | input | 1 | Host word present |
| in_data_i | input | 32 | Host word |
| in_ready_o | output | 1 | Block can take a host word |
| pix_valid_o | output | 1 | Pixel write strobe |
| pix_addr_o | output | AW | Framebuffer byte address of the pixel |
| pix_data_o | output | 32 | Pixel value, zero-extended |
| done_o | output | 1 | Final pixel written |
| busy_o | output | 1 | Blit in progress |

## Verification
A word accepted at one rising edge fills the holding register. Its first pixel is registered at the next edge, so the bench expects it one edge after the accept, counting edges with a cycle counter. It expects each further pixel one edge after the previous one, and expects done_o together with the last pixel. Ready is judged at the falling edge before each accept, and ready is expected low at the falling edge just after one. All outputs are sampled at falling edges, after the registers have settled. The expected address and data of every pixel in a full sweep of depths, widths and heights come from the byte-stream formula in the bench.

// File: rtl/hblit_pkg.sv
package hblit_pkg;
  localparam int WORD_BITS  = 32;
  localparam int WORD_BYTES = WORD_BITS / 8;

  // log2 of bytes per pixel
  typedef logic [1:0] bpp_log2_t;

  function automatic bpp_log2_t depth_to_log2(input logic [2:0] code);
    case (code)
      3'b001:  return 2'd1;
      3'b010:  return 2'd2;
      default: return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/hblit_lane_pick.sv
module hblit_lane_pick
  import hblit_pkg::*;
(
  input  logic [WORD_BITS-1:0] word_i,
  input  logic [1:0]           lane_i,
  input  bpp_log2_t            lg_i,
  output logic [WORD_BITS-1:0] pix_o
);
  localparam int N8  = WORD_BYTES;
  localparam int N16 = WORD_BYTES / 2;

  logic [WORD_BITS-1:0] view8  [N8];
  logic [WORD_BITS-1:0] view16 [N16];

  generate
    for (genvar i = 0; i < N8; i++) begin : g_b8
      assign view8[i] = {{(WORD_BITS-8){1'b0}}, word_i[8*i +: 8]};
    end
    for (genvar j = 0; j < N16; j++) begin : g_b16
      assign view16[j] = {{(WORD_BITS-16){1'b0}}, word_i[16*j +: 16]};
    end
  endgenerate

  always_comb begin
    case (lg_i)
      2'd1:    pix_o = view16[lane_i[0]];
      2'd2:    pix_o = word_i;
      default: pix_o = view8[lane_i];
    endcase
  end
endmodule

// File: rtl/hblit_seq.sv
module hblit_seq
  import hblit_pkg::*;
#(
  parameter int XW          = 12,
  parameter int YW          = 12,
  parameter int AW          = 24,
  parameter int PITCH_BYTES = 4096
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic [XW-1:0]        dst_x_i,
  input  logic [YW-1:0]        dst_y_i,
  input  logic [XW-1:0]        w_m1_i,
  input  logic [YW-1:0]        h_m1_i,
  input  logic [2:0]           depth_i,
  input  logic                 in_valid_i,
  input  logic [WORD_BITS-1:0] in_data_i,
  output logic                 in_ready_o,
  output logic                 emit_o,
  output logic                 final_o,
  output logic [AW-1:0]        emit_addr_o,
  output logic [WORD_BITS-1:0] word_o,
  output logic [1:0]           lane_o,
  output bpp_log2_t            lg_o,
  output logic                 busy_o
);
  localparam logic [AW-1:0] PITCH_A = AW'(PITCH_BYTES);

  logic                 run_q, full_q;
  logic [WORD_BITS-1:0] word_q;
  logic [1:0]           lane_q;
  logic [XW-1:0]        px_q, w_q;
  logic [YW-1:0]        row_q, h_q;
  bpp_log2_t            lg_q;
  logic [AW-1:0]        addr_q, row_base_q;

  logic      accept, row_end, last_row, lane_last;
  bpp_log2_t start_lg;
  logic [AW-1:0] start_base;

  assign in_ready_o = run_q & ~full_q;
  assign accept     = in_valid_i & in_ready_o;
  assign emit_o     = run_q & full_q;
  assign row_end    = (px_q == w_q);
  assign last_row   = (row_q == h_q);
  assign final_o    = emit_o & row_end & last_row;

  assign start_lg   = depth_to_log2(depth_i);
  assign start_base = AW'(dst_y_i) * PITCH_A + (AW'(dst_x_i) << start_lg);

  always_comb begin
    case (lg_q)
      2'd0:    lane_last = (lane_q == 2'd3);
      2'd1:    lane_last = (lane_q == 2'd1);
      default: lane_last = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q      <= 1'b0;
      full_q     <= 1'b0;
      word_q     <= '0;
      lane_q     <= '0;
      px_q       <= '0;
      w_q        <= '0;
      row_q      <= '0;
      h_q        <= '0;
      lg_q       <= '0;
      addr_q     <= '0;
      row_base_q <= '0;
    end else if (!run_q) begin
      if (start_i) begin
        run_q      <= 1'b1;
        full_q     <= 1'b0;
        w_q        <= w_m1_i;
        h_q        <= h_m1_i;
        lg_q       <= start_lg;
        row_base_q <= start_base;
        addr_q     <= start_base;
        px_q       <= '0;
        row_q      <= '0;
        lane_q     <= '0;
      end
    end else if (accept) begin
      word_q <= in_data_i;
      full_q <= 1'b1;
    end else if (emit_o) begin
      if (row_end) begin
        // pad bytes of this word are dropped here
        px_q       <= '0;
        lane_q     <= '0;
        full_q     <= 1'b0;
        row_base_q <= row_base_q + PITCH_A;
        addr_q     <= row_base_q + PITCH_A;
        if (last_row) run_q <= 1'b0;
        else          row_q <= row_q + YW'(1);
      end else begin
        px_q   <= px_q + XW'(1);
        addr_q <= addr_q + (AW'(1) << lg_q);
        if (lane_last) begin
          full_q <= 1'b0;
          lane_q <= '0;
        end else begin
          lane_q <= lane_q + 2'd1;
        end
      end
    end
  end

  assign emit_addr_o = addr_q;
  assign word_o      = word_q;
  assign lane_o      = lane_q;
  assign lg_o        = lg_q;
  assign busy_o      = run_q;

  // R7: a freshly taken word blocks the next one
  assert_hold_after_accept_R7: assert property (@(posedge clk) disable iff (rst)
    accept |=> !in_ready_o);

  // R11: geometry and depth stay fixed while a blit runs
  assert_start_ignored_R11: assert property (@(posedge clk) disable iff (rst)
    (run_q && start_i) |=> ($stable(w_q) && $stable(h_q) && $stable(lg_q)));

  // R3: a 4-byte pixel always uses the whole word
  assert_wide_lane_R3: assert property (@(posedge clk) disable iff (rst)
    (emit_o && lg_q == 2'd2) |-> (lane_q == 2'd0));
endmodule

// File: rtl/hblit_unpack.sv
module hblit_unpack
  import hblit_pkg::*;
#(
  parameter int XW          = 12,
  parameter int YW          = 12,
  parameter int AW          = 24,
  parameter int PITCH_BYTES = 4096
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [XW-1:0] dst_x_i,
  input  logic [YW-1:0] dst_y_i,
  input  logic [XW-1:0] w_m1_i,
  input  logic [YW-1:0] h_m1_i,
  input  logic [2:0]    depth_i,
  input  logic          in_valid_i,
  input  logic [31:0]   in_data_i,
  output logic          in_ready_o,
  output logic          pix_valid_o,
  output logic [AW-1:0] pix_addr_o,
  output logic [31:0]   pix_data_o,
  output logic          done_o,
  output logic          busy_o
);
  logic                 emit, fin;
  logic [AW-1:0]        emit_addr;
  logic [WORD_BITS-1:0] word, pix_val;
  logic [1:0]           lane;
  bpp_log2_t            lg;

  hblit_seq #(
    .XW(XW), .YW(YW), .AW(AW), .PITCH_BYTES(PITCH_BYTES)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .dst_x_i    (dst_x_i),
    .dst_y_i    (dst_y_i),
    .w_m1_i     (w_m1_i),
    .h_m1_i     (h_m1_i),
    .depth_i    (depth_i),
    .in_valid_i (in_valid_i),
    .in_data_i  (in_data_i),
    .in_ready_o (in_ready_o),
    .emit_o     (emit),
    .final_o    (fin),
    .emit_addr_o(emit_addr),
    .word_o     (word),
    .lane_o     (lane),
    .lg_o       (lg),
    .busy_o     (busy_o)
  );

  hblit_lane_pick u_pick (
    .word_i(word),
    .lane_i(lane),
    .lg_i  (lg),
    .pix_o (pix_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_valid_o <= 1'b0;
      pix_addr_o  <= '0;
      pix_data_o  <= '0;
      done_o      <= 1'b0;
    end else begin
      pix_valid_o <= emit;
      done_o      <= fin;
      if (emit) begin
        pix_addr_o <= emit_addr;
        pix_data_o <= pix_val;
      end
    end
  end

  // R9: done comes with the last pixel write
  assert_done_with_pixel_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> pix_valid_o);

  // R10: nothing is accepted once done
  assert_no_take_at_done_R10: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !in_ready_o);

  // R6: writes occur only inside a blit
  assert_pix_in_blit_R6: assert property (@(posedge clk) disable iff (rst)
    pix_valid_o |-> (busy_o || done_o));
endmodule

// File: tb/hblit_unpack_tb.sv
module hblit_unpack_tb;
  localparam int XW = 4, YW = 3, AW = 12, PITCH = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          start = 0, in_valid = 0;
  logic [XW-1:0] dst_x = 0, w_m1 = 0;
  logic [YW-1:0] dst_y = 0, h_m1 = 0;
  logic [2:0]    depth = 0;
  logic [31:0]   in_data = 0;
  logic          in_ready, pix_valid, done, busy;
  logic [AW-1:0] pix_addr;
  logic [31:0]   pix_data;

  hblit_unpack #(.XW(XW), .YW(YW), .AW(AW), .PITCH_BYTES(PITCH)) u_dut (
    .clk(clk), .rst(rst), .start_i(start), .dst_x_i(dst_x), .dst_y_i(dst_y),
    .w_m1_i(w_m1), .h_m1_i(h_m1), .depth_i(depth), .in_valid_i(in_valid),
    .in_data_i(in_data), .in_ready_o(in_ready), .pix_valid_o(pix_valid),
    .pix_addr_o(pix_addr), .pix_data_o(pix_data), .done_o(done), .busy_o(busy));

  int total = 0, bad = 0, cyc = 0;
  int exp_n = 0, mon_idx = 0, first_acc = 0, cur_w = 0;
  bit mon_done = 0;
  logic [AW-1:0] exp_addr [64];
  logic [31:0]   exp_data [64];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [7:0] bval(input int r, input int b);
    return 8'(r * 37 + b * 11 + 5);
  endfunction

  always @(posedge clk) begin
    if (cyc > 100000) begin
      total++; bad++;
      $display("FAIL R9 watchdog actual=%0d expected<100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // pixel monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (pix_valid) begin
        if (mon_idx == 0)
          chk(cyc == first_acc + 1, "R8", "first pixel edge", cyc, first_acc + 1);
        if (mon_idx < exp_n) begin
          chk(pix_addr == exp_addr[mon_idx], "R5", "address", pix_addr, exp_addr[mon_idx]);
          if (mon_idx > 0 && (mon_idx % (cur_w + 1)) == 0)
            chk(pix_data == exp_data[mon_idx], "R4", "row start data", pix_data, exp_data[mon_idx]);
          else
            chk(pix_data == exp_data[mon_idx], "R3", "pixel data", pix_data, exp_data[mon_idx]);
        end else begin
          chk(1'b0, "R6", "extra pixel", mon_idx, exp_n);
        end
        mon_idx++;
      end
      if (done) begin
        chk(pix_valid && mon_idx == exp_n, "R9", "done with last pixel", mon_idx, exp_n);
        chk(!busy && !in_ready, "R9", "idle at done", {busy, in_ready}, 0);
        mon_done = 1;
      end
    end
  end

  task automatic run_blit(input int dx, input int dy, input int w, input int h,
                          input int code, input bit poke);
    int bpp, rowb, dpr, nw;
    logic [31:0] words [64];
    bpp  = (code == 1) ? 2 : (code == 2) ? 4 : 1;
    rowb = (w + 1) * bpp;
    dpr  = (rowb + 3) / 4;
    nw   = dpr * (h + 1);
    for (int r = 0; r <= h; r++)
      for (int d = 0; d < dpr; d++) begin
        words[r*dpr+d] = 0;
        for (int k = 0; k < 4; k++)
          if (d*4 + k < rowb)
            words[r*dpr+d] |= 32'(bval(r, d*4 + k)) << (8*k);
      end
    for (int r = 0; r <= h; r++)
      for (int p = 0; p <= w; p++) begin
        exp_addr[r*(w+1)+p] = AW'((dy + r) * PITCH + (dx + p) * bpp);
        exp_data[r*(w+1)+p] = 0;
        for (int k = 0; k < bpp; k++)
          exp_data[r*(w+1)+p] |= 32'(bval(r, p*bpp + k)) << (8*k);
      end
    mon_idx = 0; mon_done = 0; exp_n = (w + 1) * (h + 1); cur_w = w;
    @(negedge clk);
    start = 1; dst_x = XW'(dx); dst_y = YW'(dy); w_m1 = XW'(w); h_m1 = YW'(h); depth = 3'(code);
    @(negedge clk);
    start = 0; dst_x = ~dst_x; dst_y = ~dst_y; w_m1 = ~w_m1; depth = 3'b111;
    chk(busy && in_ready, "R2", "busy and ready after start", {busy, in_ready}, 3);
    for (int i = 0; i < nw; i++) begin
      in_valid = 1; in_data = words[i];
      while (!in_ready) @(negedge clk);
      if (i == 0) first_acc = cyc + 1;
      @(negedge clk);
      in_valid = 0; in_data = 32'hA5A5_A5A5;
      if (i == 0) chk(!in_ready, "R7", "ready low while holding", in_ready, 0);
      if (poke && i == 0) begin
        start = 1; dst_x = 0; dst_y = 0; w_m1 = 0; h_m1 = 0; depth = 3'b010;
        @(negedge clk);
        start = 0;
      end
    end
    for (int t = 0; t < 500 && !mon_done; t++) @(negedge clk);
    @(negedge clk);
    chk(mon_done, "R9", "done seen", mon_done, 1);
    chk(mon_idx == exp_n, "R6", "pixel count", mon_idx, exp_n);
    if (poke) chk(mon_idx == exp_n, "R11", "start while busy ignored", mon_idx, exp_n);
    in_valid = 1; in_data = 32'h1234_5678;
    for (int t = 0; t < 3; t++) begin
      @(negedge clk);
      chk(!in_ready && !pix_valid, "R10", "no take after done", {in_ready, pix_valid}, 0);
    end
    in_valid = 0;
  endtask

  initial begin
    for (int t = 0; t < 3; t++) @(negedge clk);
    chk(!in_ready && !pix_valid && !done && !busy, "R1", "outputs in reset",
        {in_ready, pix_valid, done, busy}, 0);
    rst = 0;
    @(negedge clk);
    chk(!in_ready && !pix_valid && !done && !busy, "R1", "outputs after reset",
        {in_ready, pix_valid, done, busy}, 0);
    for (int code = 0; code < 3; code++)
      for (int w = 0; w < 7; w++)
        for (int h = 0; h < 3; h++)
          run_blit((w * 3 + code) % 5, (h + code) % 3, w, h, code, 1'b0);
    run_blit(2, 1, 4, 1, 3, 1'b0);   // R3: unused code acts as 1 byte
    run_blit(1, 2, 5, 2, 1, 1'b1);   // R11: start during blit
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule